// File: doc/BRIEF.md
# Segmented Video DAC Input Decoder

This block is the digital front end of an 8-bit segmented video digital-to-analog converter that produces composite video. It takes an 8-bit pixel code together with four picture controls (sync, blank, force-to-white and bright) and converts them into enable lines for the analog current switches:
- fifteen equal-weight coarse segments, driven as a thermometer code from the upper four code bits;
- four binary-weighted fine switches, driven directly by the lower four code bits;
- one switch for the bright boost;
- one switch for the blanking set-up offset;
- one switch for the sync current.

The controls follow a fixed priority. Sync overrides everything. Blank overrides force-to-white, bright and the pixel code. Force-to-white replaces the pixel code with full scale. Bright adds a tenth of full scale to whatever active level results.

A static feedthrough select chooses where the switch enables come from. When it is low, they come from a single register stage that captures the decoded code and the controls together on every rising clock edge. When it is high, the enables follow the inputs combinationally, and the select itself acts without a clock. The block also exports a behavioural output level, in tenths of an IRE unit, so that the analog result can be checked digitally.

The block has no stream handshake. A new pixel is taken on every clock edge and there is no back-pressure. Every input is a plain level, and an input that is held low leaves its control inactive.

Top module: `vdac_front_end`

## Requirements
- R1: Coarse segment enable k (bit k of `seg_en_o`, k = 0..14) is 1 exactly when the upper nibble (bits 7:4) of the effective code is greater than k. A code step of 16 therefore turns on exactly one more segment.
- R2: `fine_en_o` bit j equals bit j of the effective code, for j = 0..3.
- R3: With `feedthru_i` = 0, every output reflects the inputs sampled at the most recent rising edge of `clk`. A change in the inputs between edges leaves the outputs unchanged.
- R4: With `feedthru_i` = 1, the outputs follow the current inputs within the same cycle, without waiting for a clock edge.
- R5: With `sync_i` = 1, the outputs ignore the code and all other controls: `sync_en_o` = 1, `setup_en_o` = 1, every segment, fine and bright enable is 0, and `level_o` = -400.
- R6: With `blank_i` = 1 and `sync_i` = 0, the outputs ignore the code, `white_i` and `bright_i`: every segment, fine, bright and sync enable is 0, `setup_en_o` = 1, and `level_o` = 0.
- R7: With `white_i` = 1 and both `sync_i` and `blank_i` at 0, the effective code is 255: all 15 segments are on and `fine_en_o` = 4'b1111.
- R8: `bright_en_o` equals `bright_i` during active video (both `sync_i` and `blank_i` at 0) and is 0 otherwise. While it is on, `level_o` is 100 higher.
- R9: During active video, `setup_en_o` = 0, `sync_en_o` = 0, and `level_o` = 75 + (code × 925) / 255, using integer division. Code 0 gives 75 and code 255 gives 1000.
- R10: A synchronous `rst` = 1 at a rising edge loads the register with the blank state, whatever the other inputs are. With `feedthru_i` = 0, the outputs then read as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Convert clock; the register captures on the rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the blank state |
| feedthru_i | input | 1 | 1 = transparent path, 0 = registered path |
| pix_code_i | input | 8 | Pixel code, bit 7 is the MSB |
| sync_i | input | 1 | Sync request, highest priority |
| blank_i | input | 1 | Blank request |
| white_i | input | 1 | Force the code to full scale |
| bright_i | input | 1 | Add 10 % of full scale |
| seg_en_o | output | 15 | Thermometer-coded coarse segment enables |
| fine_en_o | output | 4 | Binary-weighted fine switch enables |
| bright_en_o | output | 1 | Bright boost switch enable |
| setup_en_o | output | 1 | Set-up offset switch, on while blanked or in sync |
| sync_en_o | output | 1 | Sync current switch enable |
| level_o | output | 12 | Signed behavioural output level in tenths of IRE |

## Verification
A bad decoder state shows up directly on the ports as a level outside the expected set. A segment vector that is not a clean thermometer, or a code step of 16 that does not add exactly one segment, appears as a jump in `level_o`. A control that escapes its priority appears as an enable that is on beside sync or blank.

In registered mode, a stale or skipped register stage shows up one edge after the input change. The outputs either fail to move at that edge or move before it. In transparent mode, any error appears in the same cycle as the input that causes it.

The full code range is swept under every control combination, so a wrong enable for any single code is exposed at the first vector that uses it.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  parameter int CODE_W        = 8;
  parameter int MSB_W         = 4;
  parameter int LSB_W         = CODE_W - MSB_W;
  parameter int SEG_N         = (1 << MSB_W) - 1;
  parameter int LEVEL_W       = 12;
  parameter int SYNC_TENTHS   = -400;
  parameter int SETUP_TENTHS  = 75;
  parameter int SPAN_TENTHS   = 925;
  parameter int BRIGHT_TENTHS = 100;
  parameter int CODE_MAX      = (1 << CODE_W) - 1;

  typedef struct packed {
    logic [SEG_N-1:0] seg;
    logic [LSB_W-1:0] fine;
    logic             bright;
    logic             setup;
    logic             sync;
  } sw_t;

  localparam sw_t BLANK_SW = '{seg: '0, fine: '0, bright: 1'b0, setup: 1'b1, sync: 1'b0};
endpackage

// File: rtl/vdac_ctrl_prio.sv
module vdac_ctrl_prio
  import vdac_pkg::*;
(
  input  logic [CODE_W-1:0] pix_code_i,
  input  logic              sync_i,
  input  logic              blank_i,
  input  logic              white_i,
  input  logic              bright_i,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              bright_o,
  output logic              setup_o,
  output logic              sync_o
);
  logic active;

  always_comb begin
    active = !sync_i && !blank_i;
    if (!active)      eff_code_o = '0;
    else if (white_i) eff_code_o = '1;
    else              eff_code_o = pix_code_i;
    bright_o = active && bright_i;
    setup_o  = !active;
    sync_o   = sync_i;
  end
endmodule

// File: rtl/vdac_therm_dec.sv
module vdac_therm_dec
  import vdac_pkg::*;
(
  input  logic [MSB_W-1:0] nib_i,
  output logic [SEG_N-1:0] therm_o
);
  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign therm_o[k] = (nib_i > MSB_W'(k));
  end

  logic [SEG_N-1:0] therm_inc;
  always_comb begin
    therm_inc = therm_o + SEG_N'(1);
    // R1
    therm_shape_chk: assert ((therm_inc & therm_o) == '0)
      else $error("segment vector is not a thermometer code");
  end
endmodule

// File: rtl/vdac_level_calc.sv
module vdac_level_calc
  import vdac_pkg::*;
(
  input  sw_t                       sw_i,
  output logic signed [LEVEL_W-1:0] level_o
);
  int seg_cnt;
  int code;
  int lvl;

  always_comb begin
    seg_cnt = 0;
    for (int k = 0; k < SEG_N; k++) seg_cnt += int'(sw_i.seg[k]);
    code = seg_cnt * (1 << LSB_W) + int'(sw_i.fine);
    if (sw_i.sync)       lvl = SYNC_TENTHS;
    else if (sw_i.setup) lvl = 0;
    else begin
      lvl = SETUP_TENTHS + (code * SPAN_TENTHS) / CODE_MAX;
      if (sw_i.bright) lvl += BRIGHT_TENTHS;
    end
    level_o = LEVEL_W'(lvl);
  end
endmodule

// File: rtl/vdac_front_end.sv
module vdac_front_end
  import vdac_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      feedthru_i,
  input  logic [CODE_W-1:0]         pix_code_i,
  input  logic                      sync_i,
  input  logic                      blank_i,
  input  logic                      white_i,
  input  logic                      bright_i,
  output logic [SEG_N-1:0]          seg_en_o,
  output logic [LSB_W-1:0]          fine_en_o,
  output logic                      bright_en_o,
  output logic                      setup_en_o,
  output logic                      sync_en_o,
  output logic signed [LEVEL_W-1:0] level_o
);
  logic [CODE_W-1:0] eff_code;
  logic              br_on, su_on, sy_on;
  logic [SEG_N-1:0]  therm;
  sw_t               comb_sw, reg_q, sel_sw;
  logic              armed_q;

  vdac_ctrl_prio u_prio (
    .pix_code_i(pix_code_i), .sync_i(sync_i), .blank_i(blank_i),
    .white_i(white_i), .bright_i(bright_i), .eff_code_o(eff_code),
    .bright_o(br_on), .setup_o(su_on), .sync_o(sy_on)
  );

  vdac_therm_dec u_therm (
    .nib_i(eff_code[CODE_W-1:LSB_W]),
    .therm_o(therm)
  );

  always_comb begin
    comb_sw.seg    = therm;
    comb_sw.fine   = eff_code[LSB_W-1:0];
    comb_sw.bright = br_on;
    comb_sw.setup  = su_on;
    comb_sw.sync   = sy_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= BLANK_SW;
      armed_q <= 1'b0;
    end else begin
      reg_q   <= comb_sw;
      armed_q <= 1'b1;
    end
  end

  assign sel_sw      = feedthru_i ? comb_sw : reg_q;
  assign seg_en_o    = sel_sw.seg;
  assign fine_en_o   = sel_sw.fine;
  assign bright_en_o = sel_sw.bright;
  assign setup_en_o  = sel_sw.setup;
  assign sync_en_o   = sel_sw.sync;

  vdac_level_calc u_level (
    .sw_i(sel_sw),
    .level_o(level_o)
  );

  // R3
  reg_path_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !feedthru_i) |-> (sync_en_o == $past(sync_i)))
    else $error("registered path did not follow previous edge");

  // R4
  ft_path_chk: assert property (@(posedge clk) disable iff (rst)
    feedthru_i |-> (sync_en_o == sync_i))
    else $error("transparent path did not follow inputs");

  // R5
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sync_en_o |-> (seg_en_o == '0 && fine_en_o == '0 && !bright_en_o &&
                   setup_en_o && level_o == LEVEL_W'(SYNC_TENTHS)))
    else $error("sync state not clean");

  // R6
  blank_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_en_o && !sync_en_o) |-> (level_o == '0 && seg_en_o == '0 && !bright_en_o))
    else $error("blank state not clean");

  // R9
  active_floor_chk: assert property (@(posedge clk) disable iff (rst)
    !setup_en_o |-> (!sync_en_o && level_o >= LEVEL_W'(SETUP_TENTHS)))
    else $error("active level below set-up");
endmodule

// File: tb/vdac_front_end_tb.sv
module vdac_front_end_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        feedthru_i = 1'b0;
  logic [7:0]  pix_code_i = '0;
  logic        sync_i = 1'b0, blank_i = 1'b0, white_i = 1'b0, bright_i = 1'b0;
  logic [14:0] seg_en_o;
  logic [3:0]  fine_en_o;
  logic        bright_en_o, setup_en_o, sync_en_o;
  logic signed [11:0] level_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdac_front_end u_dut (
    .clk(clk), .rst(rst), .feedthru_i(feedthru_i), .pix_code_i(pix_code_i),
    .sync_i(sync_i), .blank_i(blank_i), .white_i(white_i), .bright_i(bright_i),
    .seg_en_o(seg_en_o), .fine_en_o(fine_en_o), .bright_en_o(bright_en_o),
    .setup_en_o(setup_en_o), .sync_en_o(sync_en_o), .level_o(level_o)
  );

  // expected output vector from the requirements: {seg, fine, bright, setup, sync}
  logic [21:0] exp_vec;
  int          exp_lvl;

  task automatic model(input logic s, input logic b, input logic w, input logic br,
                       input logic [7:0] code);
    int eff;
    logic [14:0] sg;
    if (s) begin
      exp_vec = {15'd0, 4'd0, 1'b0, 1'b1, 1'b1}; exp_lvl = -400;          // R5
    end else if (b) begin
      exp_vec = {15'd0, 4'd0, 1'b0, 1'b1, 1'b0}; exp_lvl = 0;             // R6
    end else begin
      eff = w ? 255 : int'(code);                                          // R7
      for (int k = 0; k < 15; k++) sg[k] = ((eff / 16) > k);               // R1
      exp_vec = {sg, 4'(eff % 16), br, 1'b0, 1'b0};                        // R2 R8
      exp_lvl = 75 + (eff * 925) / 255 + (br ? 100 : 0);                   // R9
    end
  endtask

  task automatic check(input string tag);
    logic [21:0] act;
    act = {seg_en_o, fine_en_o, bright_en_o, setup_en_o, sync_en_o};
    n_checks++;
    if (act !== exp_vec || int'(level_o) != exp_lvl) begin
      n_fail++;
      $display("FAIL %s: actual vec=%h lvl=%0d expected vec=%h lvl=%0d",
               tag, act, level_o, exp_vec, exp_lvl);
    end
  endtask

  task automatic drive(input logic s, input logic b, input logic w, input logic br,
                       input logic [7:0] code);
    sync_i = s; blank_i = b; white_i = w; bright_i = br; pix_code_i = code;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [21:0] prev_vec;
    int          prev_lvl;
    // R10: reset with hostile inputs loads blank state
    feedthru_i = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
    repeat (2) @(posedge clk);
    #1;
    model(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 reset blank state");
    @(negedge clk); rst = 1'b0;

    // R4 transparent sweep over all codes and controls (R1 R2 R5 R6 R7 R8 R9)
    feedthru_i = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int code = 0; code < 256; code++) begin
        @(negedge clk);
        drive(c[3], c[2], c[1], c[0], 8'(code));
        #1;
        model(c[3], c[2], c[1], c[0], 8'(code));
        if (c[3])      check("R4 R5 sync override");
        else if (c[2]) check("R4 R6 blank override");
        else if (c[1]) check("R4 R7 R8 force white");
        else           check("R4 R1 R2 R8 R9 active code");
      end
    end

    // R3 registered mode: hold between edges, update at edge
    @(negedge clk);
    feedthru_i = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #1;
    model(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    prev_vec = exp_vec; prev_lvl = exp_lvl;
    check("R3 registered black");
    for (int i = 0; i < 64; i++) begin
      logic [7:0] code;
      logic s, b, w, br;
      code = 8'((i * 37 + 5) % 256);
      s = (i % 11 == 3); b = (i % 7 == 2); w = (i % 9 == 4); br = i[0];
      @(negedge clk);
      drive(s, b, w, br, code);
      #1;
      exp_vec = prev_vec; exp_lvl = prev_lvl;
      check("R3 hold until edge");
      @(posedge clk); #1;
      model(s, b, w, br, code);
      prev_vec = exp_vec; prev_lvl = exp_lvl;
      check("R3 capture at edge");
    end

    // R4 feedthrough toggles without a clock edge
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h10);
    #1;
    exp_vec = prev_vec; exp_lvl = prev_lvl;
    check("R3 before feedthrough");
    feedthru_i = 1'b1; #1;
    model(1'b0, 1'b0, 1'b0, 1'b1, 8'h10);
    check("R4 R8 feedthrough immediate");

    // R10 synchronous reset in registered mode
    @(negedge clk);
    feedthru_i = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hAA);
    rst = 1'b1;
    @(posedge clk); #1;
    model(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 reset overrides sync inputs");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    model(1'b1, 1'b0, 1'b1, 1'b1, 8'hAA);
    check("R3 R5 first capture after reset");

    finish_run();
  end
endmodule